// File: doc/BRIEF.md
# Key-locked configuration register bank

This block is a small bank of memory-mapped configuration words behind a plain single-cycle read/write bus. Each word drives a flat output bus toward the peripherals it controls. Writes to some words are guarded. A lock slot opens when its key value is written to that slot's lock register. A pair of kick registers opens a second group of words, but only while both of them hold their own key values.

A lock slot works in one of two ways. A persistent slot stays open until software writes zero, or any other non-key value, to its lock register. An auto-relocking slot stays open only for a short window of clock edges after the key write, so the protected write has to follow straight after it. A write that a closed guard refuses changes nothing and sets a sticky error flag in a status word. Software clears that flag by writing one to its bit. One configuration word holds enable bits that can be set but never cleared. Reads are never gated. Lock and kick registers read back as zero, so no key can be read out.

Top module: `kcfg_bank`

## Requirements
- R1: After reset all configuration words are zero, every lock slot is closed, both kick registers are cleared, and the status word reads zero.
- R2: A read presented at a clock edge raises `rd_valid` for exactly the following cycle, with the addressed value on `rd_data`. Locks never block a read.
- R3: Lock registers (addresses 8 to 11 for slots 0 to 3) and kick registers (addresses 12 and 13) always read as zero.
- R4: A write to a word guarded by a closed lock slot is discarded and sets status bit 0. Status bit 0 stays set until a status write (address 14) with bit 0 at one clears it.
- R5: Writing a slot's key to its lock register opens that slot for the writes that follow. Writing zero or any other value closes it at once.
- R6: An auto-relocking slot (slots 0 and 1 by default) accepts guarded writes at the RELOCK_WIN (default 4) clock edges after the edge that took the key. A write at any later edge is discarded.
- R7: A persistent slot (slots 2 and 3 by default) stays open for any number of idle cycles until it is closed.
- R8: Words in the kick group (words 4 and 5 by default) accept writes only while kick register 0 holds KICK_KEY0 and kick register 1 holds KICK_KEY1. Otherwise the write is discarded and status bit 1 is set. A status write with bit 1 at one clears bit 1.
- R9: In word WO_REG (default 7), the bits in WO_BITS (default bits 7:0) can be set by a write but are never cleared by a later write. The other bits of that word take the written value.
- R10: Unguarded words take every write. Status bits 2 to 5 show whether slots 0 to 3 are open, and status bit 6 shows whether the kick gate is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe for the current cycle |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | DATA_W | Registered read data |
| cfg_q | output | NUM_CFG*DATA_W | All configuration words, word 0 in the low bits |

## Verification
A write takes effect at the clock edge where it is presented, and the next cycle's write already sees a slot opened by it. The relock window of an auto slot is therefore counted in edges: a key followed by three idle cycles and then a write lands on the fourth edge, which is inside the window, while four idle cycles land on the fifth edge and the write is dropped. Read results arrive one cycle after the request. The driver queues each expected value when it issues the read, and the monitor compares on the falling edge after `rd_valid` rises. Direct checks of `cfg_q` are sampled on the falling edge after the write.

// File: rtl/kcfg_pkg.sv
package kcfg_pkg;
  localparam int ST_LOCK_ERR  = 0;
  localparam int ST_KICK_ERR  = 1;
  localparam int ST_OPEN_BASE = 2;

  typedef struct packed {
    logic kick;
    logic lock;
  } kcfg_err_t;
endpackage

// File: rtl/kcfg_lock_slot.sv
module kcfg_lock_slot #(
  parameter int          DATA_W     = 32,
  parameter logic [DATA_W-1:0] KEY  = '1,
  parameter bit          AUTO       = 1'b0,
  parameter int          RELOCK_WIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_val,
  output logic              open
);
  generate
    if (AUTO) begin : g_auto
      localparam int CNT_W = $clog2(RELOCK_WIN + 1);
      logic [CNT_W-1:0] win_cnt;
      always_ff @(posedge clk) begin
        if (rst)                           win_cnt <= '0;
        else if (key_wr && key_val == KEY) win_cnt <= CNT_W'(RELOCK_WIN);
        else if (key_wr)                   win_cnt <= '0;
        else if (win_cnt != '0)            win_cnt <= win_cnt - 1'b1;
      end
      assign open = (win_cnt != '0);
    end else begin : g_hold
      logic open_q;
      always_ff @(posedge clk) begin
        if (rst)         open_q <= 1'b0;
        else if (key_wr) open_q <= (key_val == KEY);
      end
      assign open = open_q;
    end
  endgenerate
endmodule

// File: rtl/kcfg_kick_gate.sv
module kcfg_kick_gate #(
  parameter int                DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY0   = '1,
  parameter logic [DATA_W-1:0] KEY1   = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr0,
  input  logic              wr1,
  input  logic [DATA_W-1:0] wdata,
  output logic              open
);
  logic [DATA_W-1:0] kick0_q, kick1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      kick0_q <= '0;
      kick1_q <= '0;
    end else begin
      if (wr0) kick0_q <= wdata;
      if (wr1) kick1_q <= wdata;
    end
  end

  assign open = (kick0_q == KEY0) && (kick1_q == KEY1);
endmodule

// File: rtl/kcfg_reg_file.sv
module kcfg_reg_file #(
  parameter int                DATA_W  = 32,
  parameter int                NUM_CFG = 8,
  parameter int                WO_REG  = 7,
  parameter logic [DATA_W-1:0] WO_BITS = '0,
  localparam int               IDX_W   = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [IDX_W-1:0]          widx,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [IDX_W-1:0]          ridx,
  output logic [DATA_W-1:0]         rdata,
  output logic [NUM_CFG*DATA_W-1:0] flat
);
  logic [DATA_W-1:0] words [NUM_CFG];

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_word
    localparam logic [DATA_W-1:0] STICKY = (i == WO_REG) ? WO_BITS : '0;
    always_ff @(posedge clk) begin
      if (rst)
        words[i] <= '0;
      else if (we && widx == IDX_W'(i))
        words[i] <= (wdata & ~STICKY) | ((wdata | words[i]) & STICKY);
    end
    assign flat[i*DATA_W +: DATA_W] = words[i];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (ridx == IDX_W'(i)) rdata = words[i];
  end
endmodule

// File: rtl/kcfg_bank.sv
module kcfg_bank #(
  parameter int  DATA_W     = 32,
  parameter int  ADDR_W     = 4,
  parameter int  NUM_CFG    = 8,
  parameter int  NUM_LOCKS  = 4,
  parameter int  RELOCK_WIN = 4,
  parameter logic [NUM_LOCKS*8-1:0]      LOCK_TGT  = {8'd3, 8'd2, 8'd1, 8'd0},
  parameter logic [NUM_LOCKS*DATA_W-1:0] LOCK_KEYS = {32'hD00D_0003, 32'hCAFE_0002,
                                                      32'hBEEF_0001, 32'h5EED_0000},
  parameter logic [NUM_LOCKS-1:0]        AUTO_MASK = 4'b0011,
  parameter logic [NUM_CFG-1:0]          KICK_MASK = 8'h30,
  parameter logic [DATA_W-1:0]           KICK_KEY0 = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0]           KICK_KEY1 = 32'h95A4_F1E0,
  parameter int                          WO_REG    = 7,
  parameter logic [DATA_W-1:0]           WO_BITS   = 32'h0000_00FF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic                      rd_valid,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NUM_CFG*DATA_W-1:0] cfg_q
);
  import kcfg_pkg::*;

  localparam int IDX_W      = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;
  localparam int LOCK_BASE  = NUM_CFG;
  localparam int KICK0_ADDR = NUM_CFG + NUM_LOCKS;
  localparam int KICK1_ADDR = KICK0_ADDR + 1;
  localparam int STAT_ADDR  = KICK0_ADDR + 2;

  logic [NUM_LOCKS-1:0] slot_open;
  logic                 kick_open;
  kcfg_err_t            err_q;

  logic             is_cfg;
  logic [IDX_W-1:0] cfg_idx;
  logic             lock_block, kick_block, cfg_we;
  logic [DATA_W-1:0] rf_rdata, stat_word;

  assign is_cfg  = (addr < ADDR_W'(NUM_CFG));
  assign cfg_idx = addr[IDX_W-1:0];

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_slot
    kcfg_lock_slot #(
      .DATA_W    (DATA_W),
      .KEY       (LOCK_KEYS[i*DATA_W +: DATA_W]),
      .AUTO      (AUTO_MASK[i]),
      .RELOCK_WIN(RELOCK_WIN)
    ) slot_i (
      .clk    (clk),
      .rst    (rst),
      .key_wr (wr_en && addr == ADDR_W'(LOCK_BASE + i)),
      .key_val(wdata),
      .open   (slot_open[i])
    );
  end

  kcfg_kick_gate #(
    .DATA_W(DATA_W),
    .KEY0  (KICK_KEY0),
    .KEY1  (KICK_KEY1)
  ) kick_i (
    .clk  (clk),
    .rst  (rst),
    .wr0  (wr_en && addr == ADDR_W'(KICK0_ADDR)),
    .wr1  (wr_en && addr == ADDR_W'(KICK1_ADDR)),
    .wdata(wdata),
    .open (kick_open)
  );

  always_comb begin
    lock_block = 1'b0;
    for (int i = 0; i < NUM_LOCKS; i++)
      if (is_cfg && cfg_idx == IDX_W'(LOCK_TGT[i*8 +: 8]) && !slot_open[i])
        lock_block = 1'b1;
    kick_block = is_cfg && KICK_MASK[cfg_idx] && !kick_open;
    cfg_we     = wr_en && is_cfg && !lock_block && !kick_block;
  end

  kcfg_reg_file #(
    .DATA_W (DATA_W),
    .NUM_CFG(NUM_CFG),
    .WO_REG (WO_REG),
    .WO_BITS(WO_BITS)
  ) rf_i (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we),
    .widx (cfg_idx),
    .wdata(wdata),
    .ridx (cfg_idx),
    .rdata(rf_rdata),
    .flat (cfg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= '0;
    end else begin
      if (wr_en && addr == ADDR_W'(STAT_ADDR)) begin
        err_q.lock <= (err_q.lock && !wdata[ST_LOCK_ERR]) || (wr_en && is_cfg && lock_block);
        err_q.kick <= (err_q.kick && !wdata[ST_KICK_ERR]) || (wr_en && is_cfg && kick_block);
      end else begin
        if (wr_en && is_cfg && lock_block) err_q.lock <= 1'b1;
        if (wr_en && is_cfg && kick_block) err_q.kick <= 1'b1;
      end
    end
  end

  always_comb begin
    stat_word                              = '0;
    stat_word[ST_LOCK_ERR]                 = err_q.lock;
    stat_word[ST_KICK_ERR]                 = err_q.kick;
    stat_word[ST_OPEN_BASE +: NUM_LOCKS]   = slot_open;
    stat_word[ST_OPEN_BASE + NUM_LOCKS]    = kick_open;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (is_cfg)                           rd_data <= rf_rdata;
        else if (addr == ADDR_W'(STAT_ADDR))  rd_data <= stat_word;
        else                                  rd_data <= '0;
      end
    end
  end
endmodule

// File: rtl/kcfg_bank_chk.sv
module kcfg_bank_chk #(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 4,
  parameter int                NUM_CFG   = 8,
  parameter int                NUM_LOCKS = 4,
  parameter logic [7:0]        TGT0      = 8'd0,
  parameter int                WO_REG    = 7,
  parameter logic [DATA_W-1:0] WO_BITS   = '0
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wr_en,
  input logic                      rd_en,
  input logic [ADDR_W-1:0]         addr,
  input logic                      clr_lock_bit,
  input logic                      rd_valid,
  input logic [DATA_W-1:0]         rd_data,
  input logic [NUM_CFG*DATA_W-1:0] cfg_q,
  input logic                      lock_err,
  input logic [NUM_LOCKS-1:0]      slot_open
);
  localparam int LOCK_BASE  = NUM_CFG;
  localparam int KICK1_ADDR = NUM_CFG + NUM_LOCKS + 1;
  localparam int STAT_ADDR  = NUM_CFG + NUM_LOCKS + 2;

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_q == '0 && !lock_err && slot_open == '0));

  p_rd_valid_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_no_valid_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  p_key_hidden_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr >= ADDR_W'(LOCK_BASE) && addr <= ADDR_W'(KICK1_ADDR)) |=> rd_data == '0);

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (lock_err && !(wr_en && addr == ADDR_W'(STAT_ADDR) && clr_lock_bit)) |=> lock_err);

  p_closed_guard_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(TGT0) && !slot_open[0])
      |=> $stable(cfg_q[TGT0*DATA_W +: DATA_W]));

  p_wo_keep_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((($past(cfg_q[WO_REG*DATA_W +: DATA_W]) & WO_BITS)
                      & ~cfg_q[WO_REG*DATA_W +: DATA_W]) == '0));
endmodule

bind kcfg_bank kcfg_bank_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .NUM_CFG  (NUM_CFG),
  .NUM_LOCKS(NUM_LOCKS),
  .TGT0     (LOCK_TGT[7:0]),
  .WO_REG   (WO_REG),
  .WO_BITS  (WO_BITS)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .clr_lock_bit(wdata[0]),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .cfg_q       (cfg_q),
  .lock_err    (err_q.lock),
  .slot_open   (slot_open)
);

// File: tb/kcfg_bank_tb_top.sv
module kcfg_bank_tb_top;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int NC = 8;

  localparam logic [DW-1:0] KEY_S0 = 32'h5EED_0000;
  localparam logic [DW-1:0] KEY_S2 = 32'hCAFE_0002;
  localparam logic [DW-1:0] KK0    = 32'h83E7_0B13;
  localparam logic [DW-1:0] KK1    = 32'h95A4_F1E0;
  localparam logic [AW-1:0] A_LK0 = 4'd8, A_LK2 = 4'd10, A_KK0 = 4'd12, A_KK1 = 4'd13, A_ST = 4'd14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic rd_valid;
  logic [DW-1:0] rd_data;
  logic [NC*DW-1:0] cfg_q;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #2.5 clk = ~clk;

  kcfg_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_valid(rd_valid), .rd_data(rd_data), .cfg_q(cfg_q)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_word(input int idx, input logic [DW-1:0] exp, input string tag);
    check(cfg_q[idx*DW +: DW] == exp, tag, cfg_q[idx*DW +: DW], exp);
  endtask

  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected rd_valid", rd_data, '0);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    check(rd_valid == 1'b0, "R1 rd_valid low after reset", {31'b0, rd_valid}, '0);
    check(cfg_q == '0, "R1 cfg words zero", cfg_q[DW-1:0], '0);
    for (int i = 0; i < NC; i++) rd(AW'(i), '0, "R1 word reads zero");
    rd(A_ST, '0, "R1 status zero");
    rd(A_LK0, '0, "R3 lock reg reads zero");

    // R10: unguarded word
    wr(4'd6, 32'hDEAD_BEEF);
    chk_word(6, 32'hDEAD_BEEF, "R10 unguarded write");
    rd(4'd6, 32'hDEAD_BEEF, "R10/R2 unguarded readback");

    // R4: closed persistent slot 2 guards word 2
    wr(4'd2, 32'h1111_2222);
    rd(4'd2, '0, "R4 closed write dropped");
    rd(A_ST, 32'h1, "R4 lock error set");
    idle(3);
    rd(A_ST, 32'h1, "R4 lock error sticky");
    wr(A_ST, 32'h1);
    rd(A_ST, '0, "R4 lock error cleared");

    // R5: wrong key keeps lock closed
    wr(A_LK2, 32'hCAFE_0000);
    wr(4'd2, 32'h5);
    rd(4'd2, '0, "R5 wrong key write dropped");
    wr(A_ST, 32'h3);

    // R5/R7: right key opens, persists
    wr(A_LK2, KEY_S2);
    rd(A_ST, 32'h10, "R10 slot2 open bit");
    rd(A_LK2, '0, "R3 key hidden");
    idle(10);
    wr(4'd2, 32'h1111_2222);
    chk_word(2, 32'h1111_2222, "R7 persistent slot accepts after idle");
    rd(4'd2, 32'h1111_2222, "R7 readback");
    wr(A_LK2, '0);
    wr(4'd2, 32'h3333);
    chk_word(2, 32'h1111_2222, "R5 zero relocks");
    rd(A_ST, 32'h1, "R5 relocked write flagged");
    wr(A_ST, 32'h1);

    // R6: auto slot 0 window
    wr(A_LK0, KEY_S0);
    wr(4'd0, 32'hA);
    chk_word(0, 32'hA, "R6 first edge in window");
    wr(A_LK0, KEY_S0);
    idle(3);
    wr(4'd0, 32'hB);
    chk_word(0, 32'hB, "R6 last edge in window");
    wr(A_LK0, KEY_S0);
    idle(4);
    wr(4'd0, 32'hC);
    chk_word(0, 32'hB, "R6 past window dropped");
    rd(A_ST, 32'h1, "R6 late write flagged");
    wr(A_ST, 32'h1);

    // R8: kick group word 4
    wr(4'd4, 32'h44);
    rd(4'd4, '0, "R8 kick closed dropped");
    rd(A_ST, 32'h2, "R8 kick error set");
    wr(A_ST, 32'h2);
    wr(A_KK0, KK0);
    wr(4'd4, 32'h44);
    chk_word(4, '0, "R8 one key not enough");
    wr(A_ST, 32'h2);
    wr(A_KK1, KK1);
    rd(A_ST, 32'h40, "R10 kick open bit");
    rd(A_KK0, '0, "R3 kick reg hidden");
    wr(4'd4, 32'h44);
    rd(4'd4, 32'h44, "R8 both keys accept");
    wr(A_KK0, '0);
    wr(4'd4, 32'h55);
    chk_word(4, 32'h44, "R8 cleared kick drops");
    rd(A_ST, 32'h2, "R8 kick error again");
    wr(A_ST, 32'h3);
    wr(A_KK1, '0);
    rd(A_ST, '0, "R4 status cleared");

    // R9: write-once low byte of word 7
    wr(4'd7, 32'h0000_00A5);
    chk_word(7, 32'h0000_00A5, "R9 set bits");
    wr(4'd7, 32'h0000_0000);
    chk_word(7, 32'h0000_00A5, "R9 clear ignored");
    wr(4'd7, 32'hFFFF_FF5A);
    chk_word(7, 32'hFFFF_FFFF, "R9 merge set");
    wr(4'd7, 32'h1234_0000);
    rd(4'd7, 32'h1234_00FF, "R9 upper bits follow write");

    idle(3);
    check(exp_q.size() == 0, "R2 all reads answered", DW'(exp_q.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule